// File: doc/BRIEF.md
# Grouped Interrupt Request Controller

This block holds the request and acknowledge logic for one shared interrupt group. Several sources feed the group, and the low-voltage detector is source 0. Each source has a detect input, a sticky request flag and an enable bit. The group adds a request flag of its own and a group enable. A global enable and a stack-full status gate every call. When all conditions hold, the block raises a one-cycle vector-call strobe and drives the group's single vector number beside it.

When the processor reports service entry, the block applies the hardware clearing rules. The global enable and the group request flag are cleared. The source flags stay set, so the handler must find and clear them itself. Software reaches every flag and enable through a small word-wide register port. Writes take effect on a clock edge, and reads are combinational.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, all four register words read 0 and `call_o` is low.
- R2: A rising edge on `det_i[i]` sets source flag i. The flag is bit i of word 1 and is visible the cycle after the edge is sampled. A detect input held high does not set the flag again after software has cleared it.
- R3: A write to word 1 loads the source flags: 0 clears a flag and 1 sets it. A detect edge in the same cycle as a write of 0 leaves that flag set.
- R4: The group request flag (word 0, bit 2) becomes set one cycle after any source flag is set, unless service entry occurs in that cycle.
- R5: `call_o` is a single-cycle pulse. It rises one cycle after the following are all true together: group flag set, some source with both its flag and its enable set, global enable set, group enable set, stack not full, and no unacknowledged call. `call_vec_o` equals the parameter `GROUP_VEC` during the pulse and is 0 otherwise.
- R6: If the global enable (word 0 bit 0), the group enable (word 0 bit 1) or the enable of the flagged source (word 2 bit i) is 0, no call is made.
- R7: While `stack_full_i` is high no call is made. A call that was held back issues one cycle after `stack_full_i` falls.
- R8: After a call, no further call is made until software writes word 0 with bit 0 set. This holds even if the global enable is still 1.
- R9: Service entry (`svc_ack_i`) clears the global enable and the group flag and leaves the source flags unchanged. If a source flag is still set, the group flag is set again on the next cycle.
- R10: Word 0 holds {group flag, group enable, global enable} in bits 2..0. Words 1 and 2 hold the flags and enables in bits NUM_SRC-1..0. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| det_i | input | NUM_SRC | Per-source detect inputs (bit 0: low-voltage detector) |
| stack_full_i | input | 1 | Call stack is full |
| svc_ack_i | input | 1 | Processor entered the group's service routine |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data of the selected word |
| call_o | output | 1 | One-cycle vector-call strobe |
| call_vec_o | output | VEC_W | Group vector number during the strobe, else 0 |

## Verification
The sweep drives every source in turn. For each source it tries all eight settings of the global enable, the group enable and the source enable. Each setting separates a gate that blocks the call from a missing gate, and the enable word either selects only the flagged source or every other source, which shows that the wrong source's enable cannot let a call through. Directed patterns then hold a detect input high across a software clear, collide a detect edge with a clearing write, keep the stack full while a call is ready, and re-arm after a call. The last directed pattern acknowledges service while a source flag remains set, which tells the automatic clear apart from the re-set on the next cycle.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    WORD_CTRL = 2'd0,
    WORD_FLAG = 2'd1,
    WORD_EN   = 2'd2,
    WORD_RSVD = 2'd3
  } word_sel_e;

  localparam int unsigned CTRL_GIE_BIT = 0;
  localparam int unsigned CTRL_GPE_BIT = 1;
  localparam int unsigned CTRL_GRQ_BIT = 2;
  localparam int unsigned CTRL_W       = 3;

  typedef struct packed {
    logic grq;
    logic gpe;
    logic gie;
  } ctrl_word_t;
endpackage

// File: rtl/grp_irq_src_bank.sv
module grp_irq_src_bank #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] det_i,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wval_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] det_q;
  logic [NUM_SRC-1:0] rise;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic flag_q, flag_d, flag_ce;

    assign rise[i] = det_i[i] & ~det_q[i];

    always_comb begin
      flag_ce = rise[i] | wr_i;
      if (rise[i])   flag_d = 1'b1;
      else if (wr_i) flag_d = wval_i[i];
      else           flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        det_q[i] <= 1'b0;
        flag_q   <= 1'b0;
      end else begin
        det_q[i] <= det_i[i];
        if (flag_ce) flag_q <= flag_d;
      end
    end

    assign flag_o[i] = flag_q;

    assert_flag_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (det_i[i] && !det_q[i]) |=> flag_o[i]);

    assert_write_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wval_i[i] && !(det_i[i] && !det_q[i])) |=> !flag_o[i]);
  end
endmodule

// File: rtl/grp_irq_regs.sv
module grp_irq_regs #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl_i,
  input  logic               gie_wval_i,
  input  logic               gpe_wval_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] en_wval_i,
  input  logic               svc_i,
  output logic               gie_o,
  output logic               gpe_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               rearm_o
);
  logic               gie_q, gie_d, gie_ce;
  logic               gpe_q, gpe_d, gpe_ce;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               en_ce;

  always_comb begin
    gie_ce = svc_i | wr_ctrl_i;
    gie_d  = svc_i ? 1'b0 : gie_wval_i;
    gpe_ce = wr_ctrl_i;
    gpe_d  = gpe_wval_i;
    en_ce  = wr_en_i;
    en_d   = en_wval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      gpe_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (gie_ce) gie_q <= gie_d;
      if (gpe_ce) gpe_q <= gpe_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  assign gie_o   = gie_q;
  assign gpe_o   = gpe_q;
  assign en_o    = en_q;
  assign rearm_o = wr_ctrl_i & gie_wval_i & ~svc_i;

  assert_svc_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i |=> !gie_o);
endmodule

// File: rtl/grp_irq_call.sv
module grp_irq_call #(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned VEC_W     = 5,
  parameter int unsigned GROUP_VEC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               gie_i,
  input  logic               gpe_i,
  input  logic               stack_full_i,
  input  logic               svc_i,
  input  logic               wr_ctrl_i,
  input  logic               grq_wval_i,
  input  logic               rearm_i,
  output logic               grq_o,
  output logic               call_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(GROUP_VEC);

  logic grq_q, grq_d, grq_ce;
  logic held_q, held_d, held_ce;
  logic call_q, call_d;
  logic any_flag, any_pend, issue;

  always_comb begin
    any_flag = |flag_i;
    any_pend = |(flag_i & en_i) & grq_q;
    issue    = any_pend & gie_i & gpe_i & ~stack_full_i & ~held_q & ~call_q;

    grq_ce = svc_i | any_flag | wr_ctrl_i;
    if (svc_i)         grq_d = 1'b0;
    else if (any_flag) grq_d = 1'b1;
    else               grq_d = grq_wval_i;

    held_ce = issue | rearm_i;
    held_d  = issue;
    call_d  = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grq_q  <= 1'b0;
      held_q <= 1'b0;
      call_q <= 1'b0;
    end else begin
      if (grq_ce)  grq_q  <= grq_d;
      if (held_ce) held_q <= held_d;
      call_q <= call_d;
    end
  end

  assign grq_o  = grq_q;
  assign call_o = call_q;
  assign vec_o  = call_q ? VEC_VAL : '0;

  assert_group_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_flag && !svc_i) |=> grq_o);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |=> !call_o);
  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(gie_i && gpe_i && grq_q));
  assert_no_call_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> $past(!stack_full_i));
  assert_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rearm_i) |=> !call_o);
  assert_svc_clears_grq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i |=> !grq_o);
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned VEC_W     = 5,
  parameter int unsigned GROUP_VEC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] det_i,
  input  logic               stack_full_i,
  input  logic               svc_ack_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               call_o,
  output logic [VEC_W-1:0]   call_vec_o
);
  if (NUM_SRC > DATA_W || DATA_W < CTRL_W) begin : g_bad_cfg
    $error("grp_irq_ctrl: register word too narrow");
  end

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  word_sel_e  sel;
  logic       wr_ctrl, wr_flag, wr_en;
  ctrl_word_t ctrl_w, ctrl_r;
  logic       wdata_unused;

  assign sel          = word_sel_e'(reg_addr_i);
  assign wr_ctrl      = reg_we_i && (sel == WORD_CTRL);
  assign wr_flag      = reg_we_i && (sel == WORD_FLAG);
  assign wr_en        = reg_we_i && (sel == WORD_EN);
  assign ctrl_w       = ctrl_word_t'(reg_wdata_i[CTRL_W-1:0]);
  assign wdata_unused = ^reg_wdata_i;

  logic [NUM_SRC-1:0] flags, ens;
  logic               gie, gpe, grq, rearm;

  grp_irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .det_i  (det_i),
    .wr_i   (wr_flag),
    .wval_i (reg_wdata_i[NUM_SRC-1:0]),
    .flag_o (flags)
  );

  grp_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_ctrl_i  (wr_ctrl),
    .gie_wval_i (ctrl_w.gie),
    .gpe_wval_i (ctrl_w.gpe),
    .wr_en_i    (wr_en),
    .en_wval_i  (reg_wdata_i[NUM_SRC-1:0]),
    .svc_i      (svc_ack_i),
    .gie_o      (gie),
    .gpe_o      (gpe),
    .en_o       (ens),
    .rearm_o    (rearm)
  );

  grp_irq_call #(
    .NUM_SRC   (NUM_SRC),
    .VEC_W     (VEC_W),
    .GROUP_VEC (GROUP_VEC)
  ) u_call (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .flag_i       (flags),
    .en_i         (ens),
    .gie_i        (gie),
    .gpe_i        (gpe),
    .stack_full_i (stack_full_i),
    .svc_i        (svc_ack_i),
    .wr_ctrl_i    (wr_ctrl),
    .grq_wval_i   (ctrl_w.grq),
    .rearm_i      (rearm),
    .grq_o        (grq),
    .call_o       (call_o),
    .vec_o        (call_vec_o)
  );

  always_comb begin
    ctrl_r.gie = gie;
    ctrl_r.gpe = gpe;
    ctrl_r.grq = grq;
    unique case (sel)
      WORD_CTRL: reg_rdata_o = DATA_W'(ctrl_r);
      WORD_FLAG: reg_rdata_o = DATA_W'(flags);
      WORD_EN:   reg_rdata_o = DATA_W'(ens);
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_src_kept_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (svc_ack_i && !wr_flag) |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;
  localparam int NS = 4;
  localparam int GV = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] det;
  logic          sfull, svc, we;
  logic [1:0]    addr;
  logic [7:0]    wdata, rdata;
  logic          call;
  logic [4:0]    vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  grp_irq_ctrl #(.NUM_SRC(NS), .DATA_W(8), .VEC_W(5), .GROUP_VEC(GV)) uut (
    .clk(clk), .rst_n(rst_n), .det_i(det), .stack_full_i(sfull),
    .svc_ack_i(svc), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .call_o(call), .call_vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    addr = a; #0.5;
    chk(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; det = '0; sfull = 0; svc = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R10 word 3 reads zero
    for (int a = 0; a < 4; a++) rd_chk("R1 reset word", 2'(a), 0);
    chk("R1 call after reset", int'(call), 0);

    // R5/R6 sweep: each source, all eight enable settings
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 8; c++) begin
        bit g, p, e, expc;
        int ok, seen;
        logic [7:0] enw;
        g = c[0]; p = c[1]; e = c[2];
        expc = g & p & e;
        enw = e ? 8'(1 << s) : 8'((~(1 << s)) & 4'hF);
        wr(2'd1, 8'h00);
        wr(2'd0, {5'd0, 1'b0, p, g});
        wr(2'd2, enw);
        addr = 2'd1;
        @(negedge clk); det[s] = 1'b1;
        ok = 1; seen = 0;
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          if (j == 0) det[s] = 1'b0;
          if (call) seen++;
          if (call !== ((expc && j == 2) ? 1'b1 : 1'b0)) ok = 0;
          if (int'(vec) !== ((expc && j == 2) ? GV : 0)) ok = 0;
        end
        chk($sformatf("R6 sweep src%0d cfg%0d call pattern", s, c), ok, 1);
        chk($sformatf("R5 sweep src%0d cfg%0d pulse count", s, c), seen, int'(expc));
        rd_chk("R2 flag readback", 2'd1, 1 << s);
        rd_chk("R4 group flag in ctrl", 2'd0, 4 | (p << 1) | g);
      end
    end

    // R3 software set and clear, collision with detect edge
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0A);
    rd_chk("R3 write ones", 2'd1, 'hA);
    wr(2'd1, 8'h00);
    rd_chk("R3 write zeros", 2'd1, 0);
    @(negedge clk); det[0] = 1'b1; we = 1'b1; addr = 2'd1; wdata = 8'h00;
    @(negedge clk); we = 1'b0; det[0] = 1'b0;
    rd_chk("R3 edge beats clear", 2'd1, 1);

    // R2 held-high detect does not re-set
    wr(2'd1, 8'h00);
    @(negedge clk); det[1] = 1'b1;
    @(negedge clk);
    rd_chk("R2 held set", 2'd1, 2);
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    rd_chk("R2 held no re-set", 2'd1, 0);
    det[1] = 1'b0;

    // R7 stack full holds the call back
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0F);
    sfull = 1'b1;
    wr(2'd0, 8'h03);
    @(negedge clk); det[2] = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 5; j++) begin
        @(negedge clk); det[2] = 1'b0;
        if (call) seen++;
      end
      chk("R7 no call while full", seen, 0);
    end
    sfull = 1'b0;
    @(negedge clk);
    chk("R7 call after full drops", int'(call), 1);
    chk("R5 vector during call", int'(vec), GV);

    // R8 no second call until re-armed
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 5; j++) begin
        @(negedge clk);
        if (call) seen++;
      end
      chk("R8 no repeat call", seen, 0);
    end
    rd_chk("R8 gie still set", 2'd0, 7);
    wr(2'd0, 8'h03);
    @(negedge clk);
    chk("R8 call after re-arm", int'(call), 1);

    // R9 service entry clears gie and group flag, keeps source flag
    @(negedge clk); svc = 1'b1;
    @(negedge clk); svc = 1'b0;
    rd_chk("R9 ctrl after service", 2'd0, 2);
    rd_chk("R9 source flag kept", 2'd1, 4);
    @(negedge clk);
    rd_chk("R9 group flag re-set", 2'd0, 6);
    repeat (3) @(negedge clk);
    chk("R9 no call with gie clear", int'(call), 0);
    rd_chk("R10 enable word", 2'd2, 'hF);
    rd_chk("R10 reserved word", 2'd3, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule